// File: doc/BRIEF.md
# Raw Entropy Word Sampler

This block turns a bank of free-running entropy bits into 64-bit words and keeps them in an on-chip word queue. The bank appears as a 128-bit input bus organised as sixteen groups of eight sources. A control write picks one group and enables the engine, the sources and the raw (unconditioned) path. While all three enables are set, the eight bits of the chosen group are captured together on every clock. Eight captures in a row make one word, which is pushed into a 64-entry queue.

A consumer pulls one word per pop request. The result appears on the data output in the cycle after the request. Production stops while the queue is full and starts again by itself as soon as a pop frees a slot. A clear command in the control write disables the unit, empties the queue and drops any partly built word. A pop from an empty queue returns zero and sets a sticky underflow flag. The current queue occupancy is always visible as a status value.

Top module: `entropy_word_sampler`

## Requirements
- R1: Every byte of a produced word comes from sources 8g to 8g+7 of the bus, where g is the group select in control bits [7:4].
- R2: Bit 8k+j of a word holds capture k (k=0 taken first) of source j of the group. The first word's push raises the level exactly 8 clocks after the enabling write edge, and then one word follows every 8 captured clocks.
- R3: The queue holds 64 words. When it is full, capturing pauses: the level stays at 64 and no word is lost or overwritten.
- R4: A pop request taken at a clock edge removes one word and shows it on pop_data after that edge. A pop from a full queue restarts production, so the level returns to 64 eight clocks later.
- R5: Words are produced only while control bits 0 (engine), 1 (entropy sources) and 2 (raw path) are all 1. With any of them 0, the level does not rise.
- R6: A control write with bit 3 set clears all control fields, empties the queue, clears the underflow flag and pop_data, and discards any partial word.
- R7: Whatever value the sources present is packed unchanged. This includes the all-zero first capture that follows enabling, which lands in byte 0 of the first word.
- R8: A control write that changes the group select restarts packing at capture 0, so no word mixes two groups.
- R9: A pop while the queue is empty returns zero on pop_data and sets underflow. The flag stays set until a clear command or rst_n.
- R10: fifo_level reports the number of stored words, from 0 to 64, and tracks pushes minus pops.
- R11: After rst_n, the level is 0, underflow is 0, pop_data is 0 and the unit is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_bits | input | 128 | Entropy source bank; group g occupies bits 8g+7..8g |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control word: [0] engine, [1] sources, [2] raw path, [3] clear, [7:4] group |
| pop | input | 1 | Pop one word from the queue |
| pop_data | output | 64 | Word delivered by the last pop (zero on empty pop) |
| fifo_level | output | 7 | Number of words held, 0..64 |
| underflow | output | 1 | Sticky flag: a pop met an empty queue |

## Verification
The checks follow the block's timing. A control write is registered at edge E, and captures happen at E+1 through E+8, so the level first goes to 1 after E+8. A pop taken at edge P changes the level and pop_data right after P, and after a pop from a full queue the level is back to 64 after P+8. The bench changes all inputs on the falling edge and reads outputs on the next falling edge. It counts edges from each write or pop, and from that count it predicts the level as floor(edges/8) minus pops. Each source byte carries its group number and a running cycle count, so order, group and continuity can be checked in every popped word.

// File: rtl/ews_pkg.sv
package ews_pkg;
  localparam int SRC_GROUPS = 16;
  localparam int SEL_W      = $clog2(SRC_GROUPS);
  localparam int CTL_W      = 4 + SEL_W;

  // control word bit positions
  localparam int B_ENG  = 0;
  localparam int B_ENT  = 1;
  localparam int B_RAW  = 2;
  localparam int B_CLR  = 3;
  localparam int B_GRP  = 4;

  typedef struct packed {
    logic [SEL_W-1:0] grp;
    logic             raw;
    logic             ent;
    logic             eng;
  } ctl_t;
endpackage

// File: rtl/ews_ctrl.sv
module ews_ctrl
  import ews_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output ctl_t             ctl,
  output logic             clr,
  output logic             restart
);
  ctl_t ctl_q, ctl_d;
  logic ld_en;

  always_comb begin
    clr     = wr_en & wr_data[B_CLR];
    restart = wr_en & ~wr_data[B_CLR] & (wr_data[B_GRP +: SEL_W] != ctl_q.grp);
    ld_en   = wr_en;
    ctl_d   = ctl_q;
    if (clr) begin
      ctl_d = '0;
    end else begin
      ctl_d.eng = wr_data[B_ENG];
      ctl_d.ent = wr_data[B_ENT];
      ctl_d.raw = wr_data[B_RAW];
      ctl_d.grp = wr_data[B_GRP +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (ld_en) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // R6: a clear command leaves every control field at zero
  p_clear_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_CLR]) |=> (ctl_q == '0));
endmodule

// File: rtl/ews_pack.sv
module ews_pack
  import ews_pkg::*;
#(
  parameter int GROUP_W = 8,
  parameter int SAMPLES = 8,
  localparam int WORD_W = GROUP_W * SAMPLES,
  localparam int KW     = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_GROUPS*GROUP_W-1:0] src,
  input  ctl_t                          ctl,
  input  logic                          restart,
  input  logic                          clr,
  input  logic                          full,
  output logic                          push,
  output logic [WORD_W-1:0]             word
);
  localparam logic [KW-1:0] K_LAST = KW'(SAMPLES - 1);

  logic [GROUP_W-1:0] grp_bits [SRC_GROUPS];
  logic [GROUP_W-1:0] sel;

  for (genvar g = 0; g < SRC_GROUPS; g++) begin : g_split
    assign grp_bits[g] = src[g*GROUP_W +: GROUP_W];
  end
  assign sel = grp_bits[ctl.grp];

  logic [KW-1:0]               k_q, k_d;
  logic [GROUP_W*(SAMPLES-1)-1:0] acc_q, acc_d;
  logic run, smp_en, st_en;

  always_comb begin
    run    = ctl.eng & ctl.ent & ctl.raw;
    smp_en = run & ~full & ~restart & ~clr;
    k_d    = k_q;
    acc_d  = acc_q;
    push   = 1'b0;
    word   = {sel, acc_q};
    if (clr || restart || !run) begin
      k_d = '0;
    end else if (smp_en) begin
      if (k_q == K_LAST) begin
        push = 1'b1;
        k_d  = '0;
      end else begin
        acc_d[k_q*GROUP_W +: GROUP_W] = sel;
        k_d = k_q + 1'b1;
      end
    end
    st_en = clr | restart | ~run | smp_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= '0;
      acc_q <= '0;
    end else if (st_en) begin
      k_q   <= k_d;
      acc_q <= acc_d;
    end
  end

  // R2: a word needs several captures, so pushes never come back to back
  p_word_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
  // R8: a group change never completes a word on the next edge
  p_restart_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !push);
endmodule

// File: rtl/ews_fifo.sv
module ews_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          underflow
);
  localparam logic [AW-1:0] P_LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] L_MAX  = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lv_q, lv_d;
  logic [DW-1:0] dq_q, dq_d;
  logic          uf_q, uf_d;
  logic          do_wr, do_rd, st_en;

  always_comb begin
    do_wr = wr_en & ~clr;
    do_rd = rd_en & ~clr & (lv_q != '0);
    wp_d  = wp_q;
    rp_d  = rp_q;
    lv_d  = lv_q;
    dq_d  = dq_q;
    uf_d  = uf_q;
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
      lv_d = '0;
      dq_d = '0;
      uf_d = 1'b0;
    end else begin
      if (do_wr) wp_d = (wp_q == P_LAST) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_d = (rp_q == P_LAST) ? '0 : rp_q + 1'b1;
      if (rd_en) begin
        dq_d = do_rd ? mem[rp_q] : '0;
        if (!do_rd) uf_d = 1'b1;
      end
      case ({do_wr, do_rd})
        2'b10:   lv_d = lv_q + 1'b1;
        2'b01:   lv_d = lv_q - 1'b1;
        default: lv_d = lv_q;
      endcase
    end
    st_en = clr | do_wr | rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      lv_q <= '0;
      dq_q <= '0;
      uf_q <= 1'b0;
    end else if (st_en) begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      lv_q <= lv_d;
      dq_q <= dq_d;
      uf_q <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  assign rd_data   = dq_q;
  assign level     = lv_q;
  assign full      = (lv_q == L_MAX);
  assign underflow = uf_q;

  // R3: the producer never pushes into a full queue
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (lv_q < L_MAX));
  // R10: occupancy stays within 0..DEPTH
  p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q <= L_MAX);
  // R10: occupancy moves by at most one word per clock unless cleared
  p_level_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (lv_q == $past(lv_q) || lv_q == $past(lv_q) + 1'b1 || lv_q + 1'b1 == $past(lv_q)));
  // R9: an empty pop yields zero and raises the flag
  p_empty_pop_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !clr && lv_q == '0) |=> (rd_data == '0 && underflow));
  // R9: the flag is sticky until a clear
  p_uf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !clr) |=> uf_q);
endmodule

// File: rtl/entropy_word_sampler.sv
module entropy_word_sampler
  import ews_pkg::*;
#(
  parameter int GROUP_W = 8,
  parameter int SAMPLES = 8,
  parameter int DEPTH   = 64
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SRC_GROUPS*GROUP_W-1:0]      src_bits,
  input  logic                               ctl_wr,
  input  logic [CTL_W-1:0]                   ctl_wdata,
  input  logic                               pop,
  output logic [GROUP_W*SAMPLES-1:0]         pop_data,
  output logic [$clog2(DEPTH+1)-1:0]         fifo_level,
  output logic                               underflow
);
  localparam int WORD_W = GROUP_W * SAMPLES;

  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ctl_t              ctl;
  logic              clr, restart, push, full;
  logic [WORD_W-1:0] word;

  ews_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (ctl_wr),
    .wr_data (ctl_wdata),
    .ctl     (ctl),
    .clr     (clr),
    .restart (restart)
  );

  ews_pack #(.GROUP_W(GROUP_W), .SAMPLES(SAMPLES)) u_pack (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .src     (src_bits),
    .ctl     (ctl),
    .restart (restart),
    .clr     (clr),
    .full    (full),
    .push    (push),
    .word    (word)
  );

  ews_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr       (clr),
    .wr_en     (push),
    .wr_data   (word),
    .rd_en     (pop),
    .rd_data   (pop_data),
    .level     (fifo_level),
    .full      (full),
    .underflow (underflow)
  );
endmodule

// File: tb/sim_entropy_word_sampler.sv
`timescale 1ns/1ps
module sim_entropy_word_sampler;
  logic         clk;
  logic         rst_n;
  logic [127:0] src_bits;
  logic         ctl_wr;
  logic [7:0]   ctl_wdata;
  logic         pop;
  logic [63:0]  pop_data;
  logic [6:0]   fifo_level;
  logic         underflow;

  int  n_vec;
  int  n_bad;
  bit  done;
  int  cyc;
  bit  zero_win;

  localparam logic [7:0] EN3 = 8'h07;
  localparam logic [7:0] CLR = 8'h08;

  entropy_word_sampler u0 (
    .clk(clk), .rst_n(rst_n), .src_bits(src_bits), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .pop(pop), .pop_data(pop_data),
    .fifo_level(fifo_level), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // source model: byte g = {g, cycle count}; forced to zero in the first capture after enabling
  function automatic logic [127:0] pattern(int c);
    logic [127:0] v;
    for (int g = 0; g < 16; g++) v[8*g +: 8] = {4'(g), 4'(c)};
    return v;
  endfunction

  always @(negedge clk) cyc <= cyc + 1;
  always_comb src_bits = zero_win ? '0 : pattern(cyc);

  function automatic bit word_ok(logic [63:0] w, int g, bit first);
    logic [3:0] base;
    logic [7:0] b;
    base = w[11:8];
    for (int k = 1; k < 8; k++) begin
      b = w[8*k +: 8];
      if (b[7:4] != 4'(g) || b[3:0] != base + 4'(k-1)) return 1'b0;
    end
    b = w[7:0];
    if (first) return b == 8'h00;
    return (b[7:4] == 4'(g)) && (b[3:0] == base - 4'd1);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] d, bit zero_after);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; zero_win = zero_after;
    @(negedge clk);
    zero_win = 1'b0;
  endtask

  task automatic pop_word(output logic [63:0] w);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    w = pop_data;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [63:0] w;
    int g, n, wt, t;
    n_vec = 0; n_bad = 0; done = 0; cyc = 0; zero_win = 0;
    ctl_wr = 0; ctl_wdata = 0; pop = 0; rst_n = 0;
    g = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(fifo_level == 0, "R11 level", 64'(fifo_level), 0);
    chk(underflow == 0, "R11 underflow", 64'(underflow), 0);
    chk(pop_data == 0, "R11 pop_data", pop_data, 0);
    repeat (20) @(negedge clk);
    chk(fifo_level == 0, "R11 disabled after reset", 64'(fifo_level), 0);

    // R9 empty pop
    pop_word(w);
    chk(w == 0, "R9 empty pop data", w, 0);
    chk(underflow == 1, "R9 underflow set", 64'(underflow), 1);
    repeat (10) @(negedge clk);
    chk(underflow == 1, "R9 underflow sticky", 64'(underflow), 1);
    wr_ctl(CLR, 0);
    chk(underflow == 0, "R6 clear drops underflow", 64'(underflow), 0);

    // R2 first-word timing, group 5
    wr_ctl({4'd5, 4'b0000} | EN3, 1);   // returns after E+1
    repeat (6) @(negedge clk);         // after E+7
    chk(fifo_level == 0, "R2 level before 8th capture", 64'(fifo_level), 0);
    @(negedge clk);                     // after E+8
    chk(fifo_level == 1, "R2 level after 8th capture", 64'(fifo_level), 1);
    repeat (8) @(negedge clk);
    chk(fifo_level == 2, "R2 second word 8 clocks later", 64'(fifo_level), 2);

    // R3 fill and pause
    repeat (600) @(negedge clk);
    chk(fifo_level == 64, "R3 full level", 64'(fifo_level), 64);
    repeat (50) @(negedge clk);
    chk(fifo_level == 64, "R3 stays full", 64'(fifo_level), 64);

    // R7 / R1 first word, R4 refill
    pop_word(w);
    chk(word_ok(w, 5, 1), "R7 first capture zero, R1 group 5", w, 0);
    chk(fifo_level == 63, "R4 pop removes one", 64'(fifo_level), 63);
    repeat (7) @(negedge clk);
    chk(fifo_level == 63, "R4 refill not before 8 clocks", 64'(fifo_level), 63);
    @(negedge clk);
    chk(fifo_level == 64, "R4 refill after 8 clocks", 64'(fifo_level), 64);
    for (int i = 0; i < 64; i++) begin
      pop_word(w);
      chk(word_ok(w, 5, 0), "R2 R1 packing order and group", w, 0);
    end

    // R6 clear while holding words
    wr_ctl(CLR, 0);
    chk(fifo_level == 0, "R6 clear empties queue", 64'(fifo_level), 0);
    chk(pop_data == 0, "R6 clear zeroes pop_data", pop_data, 0);
    repeat (40) @(negedge clk);
    chk(fifo_level == 0, "R6 unit disabled after clear", 64'(fifo_level), 0);

    // R5 gating
    wr_ctl(8'h23, 0); repeat (40) @(negedge clk);
    chk(fifo_level == 0, "R5 raw bit off", 64'(fifo_level), 0);
    wr_ctl(8'h25, 0); repeat (40) @(negedge clk);
    chk(fifo_level == 0, "R5 source bit off", 64'(fifo_level), 0);
    wr_ctl(8'h26, 0); repeat (40) @(negedge clk);
    chk(fifo_level == 0, "R5 engine bit off", 64'(fifo_level), 0);

    // R8 group change mid-word
    wr_ctl(CLR, 0);
    wr_ctl({4'd3, 4'b0000} | EN3, 1);
    repeat (2) @(negedge clk);
    wr_ctl({4'd9, 4'b0000} | EN3, 0);
    repeat (20) @(negedge clk);
    pop_word(w);
    chk(word_ok(w, 9, 0), "R8 no mixed-group word", w, 0);

    // random groups, waits and pops; R10 level model
    for (int it = 0; it < 24; it++) begin
      g  = $urandom % 16;
      n  = 1 + ($urandom % 5);
      wt = 8 * n + 8 + ($urandom % 100);
      wr_ctl(CLR, 0);
      wr_ctl(8'(g << 4) | EN3, 1);
      repeat (wt) @(negedge clk);
      for (int i = 0; i < n; i++) begin
        pop_word(w);
        chk(word_ok(w, g, i == 0), "R1 R7 random group word", w, 0);
      end
      t = 1 + wt + n;
      chk(fifo_level == 7'(t / 8 - n), "R10 level tracks pushes minus pops",
          64'(fifo_level), 64'(t / 8 - n));
    end

    done = 1;
    finish_run();
  end
endmodule